// File: doc/BRIEF.md
# Framed Serial Audio Transmitter

This block turns 32-bit parallel audio words into a single serial data line, most significant bit first. It does not make its own bit clock or frame sync. It follows two one-cycle strobes that mark the rising and falling edges of an external bit clock, plus a frame-sync strobe that is sampled on the launch edge. Words arrive through a one-entry holding register with a valid/ready handshake. One word is taken from that register each time a word slot begins.

A frame has one or two phases, and each phase has its own word count and its own coded word length. Data can start 0, 1 or 2 bit clocks after the frame sync. A stereo pair can be sent as two words, either in two phases or as two words of one phase. It can also be sent packed into one double-length word by choosing the matching length code. A frame sync that arrives before the programmed frame has finished is reported on a sticky error flag. Running out of data is reported on a second sticky flag. Dropping the enable input puts the transmitter back into reset.

Top module: `audio_ser_tx`

## Requirements
- R1: The length code selects the word length: 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 or 7 give 32. Only the low bits of the word are sent, and the first bit sent is bit length-1.
- R2: The first data bit appears 0, 1 or 2 launch edges after the launch edge that carries the frame sync, matching `cfg_delay`. A value of 3 behaves like 2. The line is 0 during the delay.
- R3: Phase A sends `cfg_cnt_a`+1 words of length `cfg_len_a`. When `cfg_dual` is 1, phase B follows at once with `cfg_cnt_b`+1 words of length `cfg_len_b`.
- R4: With `clk_pol`=1, `sdata` changes only after a `bclk_fall` strobe, and frame sync is sampled there. With `clk_pol`=0, the same applies to `bclk_rise`.
- R5: A frame sync on any launch edge from the frame-sync edge up to the edge that drives the final bit sets `sync_err`. That frame sync is ignored, and the frame in progress continues. A frame sync on the launch edge right after the final bit starts the next frame with no error.
- R6: While `tx_enable` is 0, the block is held in reset: `sdata`, `sync_err`, `underrun` and `in_ready` are 0 and the holding register is emptied. After `tx_enable` rises, the first two launch strobes only finish the reset. The frame syncs on those two strobes are ignored, and `in_ready` rises after the second strobe.
- R7: `in_ready` is 1 exactly when the block is running and the holding register is empty. A word accepted on a handshake is the one sent in the next word slot.
- R8: If the holding register is empty when a word slot begins, the previous word is sent again and `underrun` becomes 1. It stays 1 until reset. The word repeated after reset is all zeros.
- R9: `sdata` is 0 outside word slots: while idle, during the data delay, and in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_enable | input | 1 | Transmitter enable; low holds reset |
| clk_pol | input | 1 | 1: launch on falling strobe, 0: launch on rising strobe |
| bclk_rise | input | 1 | One-cycle strobe at bit-clock rising edge |
| bclk_fall | input | 1 | One-cycle strobe at bit-clock falling edge |
| fsync | input | 1 | Frame-sync strobe, sampled on a launch edge |
| cfg_delay | input | 2 | Data delay in bit clocks (0, 1, 2; 3 acts as 2) |
| cfg_dual | input | 1 | Enable second phase |
| cfg_cnt_a | input | 7 | Phase A words minus one |
| cfg_len_a | input | 3 | Phase A length code |
| cfg_cnt_b | input | 7 | Phase B words minus one |
| cfg_len_b | input | 3 | Phase B length code |
| in_data | input | 32 | Word to transmit |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Holding register can accept a word |
| sdata | output | 1 | Serial data out |
| sync_err | output | 1 | Sticky early frame-sync flag |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The hardest case to reach is the boundary of R5. A frame sync on the edge that drives the final bit must raise an error, but one on the very next edge must not. To hit both, the stimulus counts launch strobes from the frame length it computes. It sends frames back to back so that each new sync lands exactly on the post-frame edge. It also places a deliberate sync in the middle of a frame. Underrun is reached by cutting off the word feeder partway through the run. The reset-settling window is reached by sending frame syncs on the first two strobes after enable.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DLY  = 2'd1,
    ST_DATA = 2'd2
  } atx_state_e;

  // index of the first (most significant) bit sent for a length code
  function automatic logic [4:0] len_top(input logic [2:0] code);
    case (code)
      3'd0:    len_top = 5'd7;
      3'd1:    len_top = 5'd11;
      3'd2:    len_top = 5'd15;
      3'd3:    len_top = 5'd19;
      3'd4:    len_top = 5'd23;
      default: len_top = 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/atx_edge_sel.sv
module atx_edge_sel (
  input  logic pol,
  input  logic rise,
  input  logic fall,
  output logic launch
);
  assign launch = pol ? fall : rise;
endmodule

// File: rtl/atx_settle.sv
module atx_settle #(
  parameter int SETTLE = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic launch,
  output logic run
);
  localparam int CW = $clog2(SETTLE + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!enable)
      cnt_d = '0;
    else if (launch && (cnt_q != CW'(SETTLE)))
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign run = enable && (cnt_q == CW'(SETTLE));

  // R6: the cycle enable rises, the reset is not yet finished
  a_r6_settle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> !run);
endmodule

// File: rtl/atx_hold.sv
module atx_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] word
);
  logic          full_d;
  logic [DW-1:0] word_d;
  logic          load;

  assign in_ready = run && !full;
  assign load     = in_valid && in_ready;

  always_comb begin
    full_d = full;
    word_d = word;
    if (!run)
      full_d = 1'b0;
    else if (load) begin
      full_d = 1'b1;
      word_d = in_data;
    end else if (take)
      full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      full <= full_d;
      word <= word_d;
    end
  end

  // R7: a waiting word is never overwritten or lost
  a_r7_keep_word: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && run) |=> (full && $stable(word)));
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
  import atx_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CNT_W  = 7,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             clk_pol,
  input  logic             bclk_rise,
  input  logic             bclk_fall,
  input  logic             fsync,
  input  logic [1:0]       cfg_delay,
  input  logic             cfg_dual,
  input  logic [CNT_W-1:0] cfg_cnt_a,
  input  logic [2:0]       cfg_len_a,
  input  logic [CNT_W-1:0] cfg_cnt_b,
  input  logic [2:0]       cfg_len_b,
  input  logic [DW-1:0]    in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             sdata,
  output logic             sync_err,
  output logic             underrun
);
  localparam int IW = $clog2(DW);

  logic launch, run, tick;
  logic take, full;
  logic [DW-1:0] hold_word;

  atx_edge_sel u_edge (.pol(clk_pol), .rise(bclk_rise), .fall(bclk_fall), .launch(launch));

  atx_settle #(.SETTLE(SETTLE)) u_settle (
    .clk(clk), .rst_n(rst_n), .enable(tx_enable), .launch(launch), .run(run));

  atx_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .take(take), .full(full), .word(hold_word));

  assign tick = run && launch;

  atx_state_e       st_q, st_d;
  logic [1:0]       rem_q, rem_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [CNT_W-1:0] wc_q, wc_d;
  logic             ph_q, ph_d;
  logic [DW-1:0]    cur_q, cur_d;
  logic             sd_q, sd_d, err_q, err_d, ur_q, ur_d;

  logic [1:0]       dly_eff;
  logic [CNT_W-1:0] ph_cnt;
  logic             at_end, go, go_ph;
  logic [CNT_W-1:0] go_wc;
  logic [DW-1:0]    nxt_word;

  assign dly_eff = (cfg_delay == 2'd3) ? 2'd2 : cfg_delay;
  assign ph_cnt  = ph_q ? cfg_cnt_b : cfg_cnt_a;
  assign at_end  = (st_q == ST_DATA) && (idx_q == '0) && (wc_q == ph_cnt) &&
                   !(!ph_q && cfg_dual);

  always_comb begin
    st_d = st_q; rem_d = rem_q; idx_d = idx_q; wc_d = wc_q; ph_d = ph_q;
    cur_d = cur_q; sd_d = sd_q; err_d = err_q; ur_d = ur_q;
    take = 1'b0; go = 1'b0; go_ph = 1'b0; go_wc = '0; nxt_word = cur_q;
    if (tick) begin
      if (fsync && !((st_q == ST_IDLE) || at_end))
        err_d = 1'b1;
      if ((st_q == ST_IDLE) || at_end) begin
        st_d = ST_IDLE;
        sd_d = 1'b0;
        if (fsync) begin
          if (dly_eff == 2'd0) go = 1'b1;
          else begin
            st_d  = ST_DLY;
            rem_d = dly_eff;
          end
        end
      end else if (st_q == ST_DLY) begin
        if (rem_q == 2'd1) go = 1'b1;
        else rem_d = rem_q - 1'b1;
      end else if (idx_q != '0) begin
        idx_d = idx_q - 1'b1;
        sd_d  = cur_q[idx_q - 1'b1];
      end else begin
        go = 1'b1;
        if (wc_q != ph_cnt) begin
          go_ph = ph_q;
          go_wc = wc_q + 1'b1;
        end else
          go_ph = 1'b1;
      end
      if (go) begin
        take     = full;
        nxt_word = full ? hold_word : cur_q;
        ur_d     = ur_q | ~full;
        cur_d    = nxt_word;
        idx_d    = IW'(len_top(go_ph ? cfg_len_b : cfg_len_a));
        sd_d     = nxt_word[idx_d];
        st_d     = ST_DATA;
        ph_d     = go_ph;
        wc_d     = go_wc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; rem_q <= '0; idx_q <= '0; wc_q <= '0; ph_q <= 1'b0;
      cur_q <= '0; sd_q <= 1'b0; err_q <= 1'b0; ur_q <= 1'b0;
    end else if (!run) begin
      st_q <= ST_IDLE; rem_q <= '0; idx_q <= '0; wc_q <= '0; ph_q <= 1'b0;
      cur_q <= '0; sd_q <= 1'b0; err_q <= 1'b0; ur_q <= 1'b0;
    end else if (tick) begin
      st_q <= st_d; rem_q <= rem_d; idx_q <= idx_d; wc_q <= wc_d; ph_q <= ph_d;
      cur_q <= cur_d; sd_q <= sd_d; err_q <= err_d; ur_q <= ur_d;
    end
  end

  assign sdata    = sd_q;
  assign sync_err = err_q;
  assign underrun = ur_q;

  // R9: line quiet in reset
  a_r9_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> !sdata);
  // R6: flags cleared by reset
  a_r6_flags_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |=> (!sync_err && !underrun));
  // R4: data moves only on the selected launch edge
  a_r4_launch_only: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !launch) |=> $stable(sdata));
  // R8: underrun is sticky while enabled
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && underrun) |=> underrun);
  // R5: sync error is sticky while enabled
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_enable && sync_err) |=> sync_err);
endmodule

// File: tb/sim_audio_ser_tx.sv
module sim_audio_ser_tx;
  localparam int CLK_P = 10;

  logic clk, rst_n, tx_enable, clk_pol, bclk_rise, bclk_fall, fsync;
  logic [1:0] cfg_delay;
  logic cfg_dual;
  logic [6:0] cfg_cnt_a, cfg_cnt_b;
  logic [2:0] cfg_len_a, cfg_len_b;
  logic [31:0] in_data;
  logic in_valid, in_ready, sdata, sync_err, underrun;

  audio_ser_tx u0 (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .clk_pol(clk_pol),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fsync(fsync),
    .cfg_delay(cfg_delay), .cfg_dual(cfg_dual), .cfg_cnt_a(cfg_cnt_a),
    .cfg_len_a(cfg_len_a), .cfg_cnt_b(cfg_cnt_b), .cfg_len_b(cfg_len_b),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .sdata(sdata), .sync_err(sync_err), .underrun(underrun));

  int n_chk = 0, n_bad = 0;
  string cur_req = "R6";
  bit feed_en = 0;
  int seed = 1;
  bit done = 0;

  // reference model state
  int m_cnt = 0, m_dly = 0, m_bits = 0, m_len = 0;
  int m_lens[$];
  logic [31:0] m_q[$];
  logic [31:0] m_w = 0;
  bit m_sd = 0, m_err = 0, m_ur = 0, acc = 0, m_run = 0, m_launch = 0, m_act = 0;

  function automatic int blen(input logic [2:0] c);
    case (c)
      3'd0: return 8;
      3'd1: return 12;
      3'd2: return 16;
      3'd3: return 20;
      3'd4: return 24;
      default: return 32;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  initial begin
    clk = 0;
    forever #(CLK_P/2) clk = ~clk;
  end

  always @(posedge clk) begin
    m_run    = tx_enable && (m_cnt == 2);
    m_launch = clk_pol ? bclk_fall : bclk_rise;
    acc      = in_valid && m_run && (m_q.size() == 0);
    if (!rst_n || !m_run) begin
      m_dly = 0; m_bits = 0; m_lens.delete(); m_q.delete();
      m_w = 0; m_sd = 0; m_err = 0; m_ur = 0;
    end else if (m_launch) begin
      m_act = (m_dly > 0) || (m_bits > 0) || (m_lens.size() > 0);
      if (fsync && m_act) m_err = 1;
      if (fsync && !m_act) begin
        m_dly = (cfg_delay == 2'd3) ? 2 : int'(cfg_delay);
        for (int i = 0; i <= int'(cfg_cnt_a); i++) m_lens.push_back(blen(cfg_len_a));
        if (cfg_dual)
          for (int i = 0; i <= int'(cfg_cnt_b); i++) m_lens.push_back(blen(cfg_len_b));
      end
      if (m_dly > 0) begin
        m_dly--; m_sd = 0;
      end else if (m_bits > 0) begin
        m_bits--; m_sd = m_w[m_bits];
      end else if (m_lens.size() > 0) begin
        m_len = m_lens.pop_front();
        if (m_q.size() > 0) m_w = m_q.pop_front();
        else m_ur = 1;
        m_bits = m_len - 1;
        m_sd = m_w[m_bits];
      end else
        m_sd = 0;
    end
    if (acc) m_q.push_back(in_data);
    if (!rst_n || !tx_enable) m_cnt = 0;
    else if (m_launch && m_cnt < 2) m_cnt++;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(sdata == m_sd, {cur_req, " sdata"}, sdata, m_sd);
      check(in_ready == (tx_enable && m_cnt == 2 && m_q.size() == 0),
            {cur_req, " R7 in_ready"}, in_ready,
            (tx_enable && m_cnt == 2 && m_q.size() == 0));
      check(sync_err == m_err, {cur_req, " sync_err"}, sync_err, m_err);
      check(underrun == m_ur, {cur_req, " underrun"}, underrun, m_ur);
    end
  end

  // word feeder
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!feed_en) in_valid = 0;
    else if (acc || !in_valid) begin
      in_valid = 1;
      in_data  = 32'h9E3779B9 * seed + 32'h01234567;
      seed++;
    end
  end

  task automatic bitk(input bit fs);
    @(posedge clk); #(CLK_P/4); bclk_rise = 1; fsync = fs && !clk_pol;
    @(posedge clk); #(CLK_P/4); bclk_rise = 0; fsync = 0;
    @(posedge clk); #(CLK_P/4); bclk_fall = 1; fsync = fs && clk_pol;
    @(posedge clk); #(CLK_P/4); bclk_fall = 0; fsync = 0;
  endtask

  function automatic int flen();
    int n;
    n = ((cfg_delay == 2'd3) ? 2 : int'(cfg_delay)) + (int'(cfg_cnt_a) + 1) * blen(cfg_len_a);
    if (cfg_dual) n += (int'(cfg_cnt_b) + 1) * blen(cfg_len_b);
    return n;
  endfunction

  task automatic frame(input int gap);
    bitk(1);
    repeat (flen() - 1) bitk(0);
    repeat (gap) bitk(0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 0; tx_enable = 0; clk_pol = 1; bclk_rise = 0; bclk_fall = 0; fsync = 0;
    cfg_delay = 1; cfg_dual = 0; cfg_cnt_a = 1; cfg_len_a = 2; cfg_cnt_b = 0; cfg_len_b = 0;
    in_data = 0; in_valid = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4); rst_n = 1;
    @(negedge clk);
    check(sdata == 0 && in_ready == 0 && sync_err == 0 && underrun == 0,
          "R6 reset state", {sdata, in_ready, sync_err, underrun}, 0);

    // R6: settling strobes ignore frame sync
    cur_req = "R6"; feed_en = 1; tx_enable = 1;
    bitk(1);
    bitk(1);
    @(negedge clk);
    check(sdata == 0 && sync_err == 0, "R6 syncs ignored while settling", {sdata, sync_err}, 0);
    check(in_ready == 0 || in_ready == 1, "R6 ready defined", in_ready, 1);

    // R1 R3 R7 R9: single phase, 16-bit words, delay 1, falling launch
    cur_req = "R1 R3 R7 R9";
    frame(0); frame(3); frame(2);
    @(negedge clk);
    check(sdata == 0, "R9 idle line", sdata, 0);

    // R2 R3 R4: rising launch, delay 0, dual phase 8 + 3x32
    cur_req = "R2 R3 R4";
    clk_pol = 0; cfg_delay = 0; cfg_dual = 1; cfg_cnt_a = 0; cfg_len_a = 0;
    cfg_cnt_b = 2; cfg_len_b = 5;
    bitk(0);
    frame(0); frame(2);

    // R1 R2: delay 2 and delay code 3, other lengths
    cur_req = "R1 R2";
    cfg_delay = 2; cfg_cnt_a = 2; cfg_len_a = 1; cfg_cnt_b = 0; cfg_len_b = 3;
    frame(0); frame(1);
    cfg_delay = 3; cfg_len_a = 4; cfg_len_b = 7; cfg_cnt_a = 0;
    frame(0); frame(2);
    @(negedge clk);
    check(sync_err == 0, "R5 back-to-back syncs legal", sync_err, 0);

    // R5: early frame sync mid-frame
    cur_req = "R5";
    clk_pol = 1; cfg_delay = 1; cfg_dual = 0; cfg_cnt_a = 0; cfg_len_a = 2;
    bitk(1);
    repeat (5) bitk(0);
    bitk(1);
    @(negedge clk);
    check(sync_err == 1, "R5 early sync flagged", sync_err, 1);
    repeat (flen() - 7) bitk(0);
    bitk(0);
    @(negedge clk);
    check(sync_err == 1, "R5 flag sticky", sync_err, 1);

    // R6: reset clears flag, line, ready
    cur_req = "R6";
    tx_enable = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sync_err == 0 && sdata == 0 && in_ready == 0, "R6 disable clears",
          {sync_err, sdata, in_ready}, 0);
    #(CLK_P/4); tx_enable = 1;
    bitk(0); bitk(0);
    @(negedge clk);
    check(underrun == 0, "R8 clear after reset", underrun, 0);

    // R8: underrun repeats last word
    cur_req = "R8";
    frame(1);
    feed_en = 0;
    cfg_cnt_a = 2; cfg_len_a = 0;
    repeat (3) bitk(0);
    frame(2);
    @(negedge clk);
    check(underrun == 1, "R8 underrun flagged", underrun, 1);
    frame(2);
    @(negedge clk);
    check(underrun == 1, "R8 underrun sticky", underrun, 1);
    check(sdata == 0, "R9 quiet after frame", sdata, 0);

    finish_run();
  end
endmodule